// File: doc/BRIEF.md
# Circular trace buffer capture controller

This block steers the write side of a logic analyser's trace RAM. The host programs a region, a post-trigger write budget and a sampling decimation, then sets the enable bit as its final configuration write. From that point the block emits a write strobe and an address for every kept sample. The pointer wraps around inside the region, so the RAM always holds the most recent history.

When a trigger arrives from hardware or from software, the block records where the pointer stood and samples an external free-running timestamp. It then allows exactly the programmed number of further writes and stops. Status outputs report the capture state, the pointer and timestamp taken at the trigger, and whether the region has wrapped at least once. Until the first wrap, part of the RAM still holds stale contents. The RAM itself, the data path and readback live outside this block.

The region runs from `{start_hi, 10'h000}` to `{last_hi, 10'h3FF}`, so it is a whole number of 1024-entry pages. Region bounds and the decimation rate are captured when the block arms. The post-trigger count is captured when the trigger fires.

Top module: `trace_capture_ctrl`

## Requirements
- R1: After reset, st_state is 0 (idle), st_first_fill is 1, st_trig_ptr and st_trig_stamp are 0, and mem_we stays low.
- R2: While cfg_enable is low, mem_we is never asserted. In idle, cfg_enable high moves st_state to 1 (pre-trigger) at the next edge, and the first write then goes to address `{cfg_start_hi, 10'h000}`.
- R3: Each write goes to the address after the previous one. The write after the one at `{cfg_last_hi, 10'h3FF}` goes back to `{cfg_start_hi, 10'h000}`.
- R4: st_first_fill is set to 1 on arming and clears at the edge that ends the write to the region's last address. It then stays 0 until the next arming.
- R5: With cfg_rate = N ≥ 2, only the 1st, (N+1)th, (2N+1)th … sample_valid cycles since arming produce a write. With N of 0 or 1, every sample is written.
- R6: A trigger in the pre-trigger state latches into st_trig_ptr the address written in that cycle, or the address the next write will use if there is no write that cycle. It also latches ts_in into st_trig_stamp. Both become visible after that edge.
- R7: With cfg_post_count = K > 0, the trigger moves st_state to 2 (post-trigger). Exactly K further writes follow the trigger cycle, then st_state becomes 3 (done), and no write occurs in done.
- R8: With cfg_post_count = 0, the trigger moves st_state straight to 3, and no write follows the trigger cycle.
- R9: Done holds until cfg_enable is cleared, then returns to idle. Triggers outside the pre-trigger state leave st_trig_ptr and st_trig_stamp unchanged.
- R10: sw_trigger has exactly the same effect as hw_trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_enable | input | 1 | Capture enable, written last |
| cfg_start_hi | input | 8 | Upper bits of the region start address |
| cfg_last_hi | input | 8 | Upper bits of the region's last page |
| cfg_post_count | input | 18 | Writes allowed after the trigger |
| cfg_rate | input | 5 | Keep one sample in N |
| sample_valid | input | 1 | A monitored sample is present this cycle |
| hw_trigger | input | 1 | Hardware trigger |
| sw_trigger | input | 1 | Software trigger |
| ts_in | input | 32 | Free-running timestamp |
| mem_we | output | 1 | Trace RAM write strobe |
| mem_addr | output | 18 | Trace RAM write address |
| st_state | output | 2 | 0 idle, 1 pre-trigger, 2 post-trigger, 3 done |
| st_trig_ptr | output | 18 | Pointer latched at the trigger |
| st_trig_stamp | output | 32 | Timestamp latched at the trigger |
| st_first_fill | output | 1 | Region not yet wrapped since arming |

## Verification
Several properties are checked on every cycle: no write while disabled or done, writes staying inside the region in consecutive or wrapped order, the first-fill flag never returning to 1 without passing through idle, the trigger records holding still outside the pre-trigger state, and a zero budget going straight to done. Other behaviour depends on exact counts and values, so only the directed scenarios can show it. These are the decimation phase, the exact number of post-trigger writes, the latched pointer when the trigger lands on a cycle without a write, the captured timestamp value, and the first-fill clear on the 1024th write.

// File: rtl/trace_cap_pkg.sv
package trace_cap_pkg;

    parameter int HI_W    = 8;
    parameter int PAGE_W  = 10;
    parameter int POST_W  = 18;
    parameter int RATE_W  = 5;
    parameter int TS_W    = 32;
    localparam int PTR_W  = HI_W + PAGE_W;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PRE  = 2'd1,
        ST_POST = 2'd2,
        ST_DONE = 2'd3
    } cap_state_e;

    typedef struct packed {
        logic [PTR_W-1:0] base;
        logic [PTR_W-1:0] last;
    } region_t;

    typedef struct packed {
        logic [PTR_W-1:0] ptr;
        logic [TS_W-1:0]  stamp;
    } trig_rec_t;

    function automatic region_t make_region(input logic [HI_W-1:0] start_hi,
                                            input logic [HI_W-1:0] last_hi);
        region_t r;
        r.base = {start_hi, {PAGE_W{1'b0}}};
        r.last = {last_hi, {PAGE_W{1'b1}}};
        return r;
    endfunction

    function automatic logic [PTR_W-1:0] step_ptr(input logic [PTR_W-1:0] cur,
                                                  input region_t r);
        return (cur == r.last) ? r.base : cur + 1'b1;
    endfunction

endpackage

// File: rtl/tc_decimator.sv
module tc_decimator
    import trace_cap_pkg::*;
#(
    parameter int W = RATE_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clear,
    input  logic         sample,
    input  logic [W-1:0] rate,
    output logic         hit
);
    logic [W-1:0] cnt;
    logic [W:0]   cnt_inc;

    assign cnt_inc = {1'b0, cnt} + 1'b1;
    assign hit     = sample && (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt <= '0;
        end else if (sample) begin
            if (cnt_inc >= {1'b0, rate}) cnt <= '0;
            else                         cnt <= cnt_inc[W-1:0];
        end
    end
endmodule

// File: rtl/tc_addr_gen.sv
module tc_addr_gen
    import trace_cap_pkg::*;
#(
    parameter int HW = HI_W,
    parameter int PW = PAGE_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           load,
    input  logic [HW-1:0]  start_hi,
    input  logic [HW-1:0]  last_hi,
    input  logic           advance,
    output logic [PTR_W-1:0] ptr,
    output region_t        region,
    output logic           at_last
);
    region_t reg_q;

    assign region  = reg_q;
    assign at_last = advance && (ptr == reg_q.last);

    always_ff @(posedge clk) begin
        if (rst) begin
            reg_q <= '0;
            ptr   <= '0;
        end else if (load) begin
            reg_q <= make_region(start_hi, last_hi);
            ptr   <= make_region(start_hi, last_hi).base;
        end else if (advance) begin
            ptr <= step_ptr(ptr, reg_q);
        end
    end
endmodule

// File: rtl/tc_fsm.sv
module tc_fsm
    import trace_cap_pkg::*;
#(
    parameter int PW = POST_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          enable,
    input  logic          trigger,
    input  logic          wr,
    input  logic [PW-1:0] post_count,
    output cap_state_e    state,
    output logic          arm,
    output logic          capturing,
    output logic          trig_fire
);
    cap_state_e   state_q, state_d;
    logic [PW-1:0] remain_q, remain_d;

    assign state     = state_q;
    assign arm       = (state_q == ST_IDLE) && enable;
    assign capturing = enable && ((state_q == ST_PRE) || (state_q == ST_POST));
    assign trig_fire = (state_q == ST_PRE) && enable && trigger;

    always_comb begin
        state_d  = state_q;
        remain_d = remain_q;
        unique case (state_q)
            ST_IDLE: if (enable) state_d = ST_PRE;
            ST_PRE: begin
                if (!enable) begin
                    state_d = ST_IDLE;
                end else if (trigger) begin
                    remain_d = post_count;
                    state_d  = (post_count == '0) ? ST_DONE : ST_POST;
                end
            end
            ST_POST: begin
                if (!enable) begin
                    state_d = ST_IDLE;
                end else if (wr) begin
                    remain_d = remain_q - 1'b1;
                    if (remain_q == {{(PW-1){1'b0}}, 1'b1}) state_d = ST_DONE;
                end
            end
            ST_DONE: if (!enable) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            remain_q <= '0;
        end else begin
            state_q  <= state_d;
            remain_q <= remain_d;
        end
    end
endmodule

// File: rtl/trace_capture_ctrl.sv
module trace_capture_ctrl
    import trace_cap_pkg::*;
#(
    parameter int HW  = HI_W,
    parameter int PGW = PAGE_W,
    parameter int PCW = POST_W,
    parameter int RW  = RATE_W,
    parameter int TW  = TS_W,
    localparam int AW = HW + PGW
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           cfg_enable,
    input  logic [HW-1:0]  cfg_start_hi,
    input  logic [HW-1:0]  cfg_last_hi,
    input  logic [PCW-1:0] cfg_post_count,
    input  logic [RW-1:0]  cfg_rate,
    input  logic           sample_valid,
    input  logic           hw_trigger,
    input  logic           sw_trigger,
    input  logic [TW-1:0]  ts_in,
    output logic           mem_we,
    output logic [AW-1:0]  mem_addr,
    output logic [1:0]     st_state,
    output logic [AW-1:0]  st_trig_ptr,
    output logic [TW-1:0]  st_trig_stamp,
    output logic           st_first_fill
);
    cap_state_e state;
    logic       arm, capturing, trig_fire, hit, at_last;
    logic [RW-1:0] rate_q;
    region_t    region;
    logic [AW-1:0] ptr;
    trig_rec_t  rec_q;
    logic       first_fill_q;

    tc_fsm #(.PW(PCW)) u_fsm (
        .clk(clk), .rst(rst), .enable(cfg_enable),
        .trigger(hw_trigger || sw_trigger), .wr(mem_we),
        .post_count(cfg_post_count), .state(state), .arm(arm),
        .capturing(capturing), .trig_fire(trig_fire)
    );

    always_ff @(posedge clk) begin
        if (rst)      rate_q <= '0;
        else if (arm) rate_q <= cfg_rate;
    end

    tc_decimator #(.W(RW)) u_dec (
        .clk(clk), .rst(rst), .clear(arm),
        .sample(sample_valid && capturing), .rate(rate_q), .hit(hit)
    );

    tc_addr_gen #(.HW(HW), .PW(PGW)) u_addr (
        .clk(clk), .rst(rst), .load(arm),
        .start_hi(cfg_start_hi), .last_hi(cfg_last_hi),
        .advance(mem_we), .ptr(ptr), .region(region), .at_last(at_last)
    );

    assign mem_we   = hit;
    assign mem_addr = ptr;

    always_ff @(posedge clk) begin
        if (rst) begin
            rec_q        <= '0;
            first_fill_q <= 1'b1;
        end else begin
            if (trig_fire) begin
                rec_q.ptr   <= ptr;
                rec_q.stamp <= ts_in;
            end
            if (arm)          first_fill_q <= 1'b1;
            else if (at_last) first_fill_q <= 1'b0;
        end
    end

    assign st_state      = state;
    assign st_trig_ptr   = rec_q.ptr;
    assign st_trig_stamp = rec_q.stamp;
    assign st_first_fill = first_fill_q;
endmodule

// File: rtl/trace_capture_ctrl_chk.sv
module trace_capture_ctrl_chk
    import trace_cap_pkg::*;
#(
    parameter int AW  = PTR_W,
    parameter int TW  = TS_W,
    parameter int PCW = POST_W
) (
    input logic           clk,
    input logic           rst,
    input logic           en,
    input logic           hw_t,
    input logic           sw_t,
    input logic [PCW-1:0] post,
    input logic           we,
    input logic [AW-1:0]  addr,
    input logic [1:0]     state,
    input logic [AW-1:0]  tptr,
    input logic [TW-1:0]  tstamp,
    input logic           ffill,
    input logic [AW-1:0]  base,
    input logic [AW-1:0]  last
);
    logic [AW-1:0] prev_addr;
    logic          have_prev;

    always_ff @(posedge clk) begin
        if (rst || state == 2'd0) begin
            have_prev <= 1'b0;
            prev_addr <= '0;
        end else if (we) begin
            have_prev <= 1'b1;
            prev_addr <= addr;
        end
    end

    // R2
    a_r2_no_write_disabled: assert property (@(posedge clk) disable iff (rst)
        !en |-> !we);
    // R3
    a_r3_in_region: assert property (@(posedge clk) disable iff (rst)
        (we && base <= last) |-> (addr >= base && addr <= last));
    a_r3_sequential: assert property (@(posedge clk) disable iff (rst)
        (we && have_prev) |-> ((addr == prev_addr + 1'b1) ||
                               (prev_addr == last && addr == base)));
    // R4
    a_r4_fill_sticky: assert property (@(posedge clk) disable iff (rst)
        (!ffill && state != 2'd0) |=> !ffill);
    // R7
    a_r7_done_quiet: assert property (@(posedge clk) disable iff (rst)
        (state == 2'd3) |-> !we);
    // R8
    a_r8_zero_budget: assert property (@(posedge clk) disable iff (rst)
        (state == 2'd1 && en && (hw_t || sw_t) && post == '0) |=> state == 2'd3);
    // R9
    a_r9_record_hold: assert property (@(posedge clk) disable iff (rst)
        (state != 2'd1) |=> ($stable(tptr) && $stable(tstamp)));
endmodule

bind trace_capture_ctrl trace_capture_ctrl_chk #(.AW(AW), .TW(TW), .PCW(PCW)) u_chk (
    .clk(clk), .rst(rst), .en(cfg_enable), .hw_t(hw_trigger), .sw_t(sw_trigger),
    .post(cfg_post_count), .we(mem_we), .addr(mem_addr), .state(st_state),
    .tptr(st_trig_ptr), .tstamp(st_trig_stamp), .ffill(st_first_fill),
    .base(region.base), .last(region.last)
);

// File: tb/trace_capture_ctrl_test.sv
module trace_capture_ctrl_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_enable = 1'b0;
    logic [7:0]  cfg_start_hi = '0;
    logic [7:0]  cfg_last_hi = '0;
    logic [17:0] cfg_post_count = '0;
    logic [4:0]  cfg_rate = '0;
    logic        sample_valid = 1'b0;
    logic        hw_trigger = 1'b0;
    logic        sw_trigger = 1'b0;
    logic [31:0] ts_in = '0;
    logic        mem_we;
    logic [17:0] mem_addr;
    logic [1:0]  st_state;
    logic [17:0] st_trig_ptr;
    logic [31:0] st_trig_stamp;
    logic        st_first_fill;

    int checks = 0;
    int fails  = 0;
    logic finished = 1'b0;

    always #2 clk = ~clk;

    trace_capture_ctrl uut (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // one clock: drive at negedge, sample write port, pass the posedge
    task automatic tick(input logic sv, input logic hw, input logic sw,
                        output logic we, output logic [17:0] ad);
        @(negedge clk);
        sample_valid = sv; hw_trigger = hw; sw_trigger = sw;
        #1;
        we = mem_we; ad = mem_addr;
        @(posedge clk);
        #1;
    endtask

    task automatic t_reset();
        logic we; logic [17:0] ad;
        chk("R1 state", st_state, 0);
        chk("R1 first_fill", st_first_fill, 1);
        chk("R1 trig_ptr", st_trig_ptr, 0);
        chk("R1 stamp", st_trig_stamp, 0);
        tick(1, 0, 0, we, ad);
        chk("R1/R2 no write when disabled", we, 0);
    endtask

    task automatic t_basic();
        logic we; logic [17:0] ad;
        cfg_start_hi = 8'd3; cfg_last_hi = 8'd3; cfg_rate = 0; cfg_post_count = 18'd4;
        cfg_enable = 1'b1;
        tick(0, 0, 0, we, ad);
        chk("R2 arm state", st_state, 1);
        for (int i = 0; i < 5; i++) begin
            tick(1, 0, 0, we, ad);
            chk("R2/R3 write strobe", we, 1);
            chk("R2/R3 write addr", ad, 18'hC00 + i);
        end
        ts_in = 32'h1234_5678;
        tick(1, 1, 0, we, ad);
        chk("R6 trigger write addr", ad, 18'hC05);
        chk("R7 post state", st_state, 2);
        chk("R6 trig_ptr", st_trig_ptr, 18'hC05);
        chk("R6 stamp", st_trig_stamp, 32'h1234_5678);
        tick(0, 0, 0, we, ad);
        chk("R7 no sample no write", we, 0);
        for (int i = 0; i < 4; i++) begin
            tick(1, 0, 0, we, ad);
            chk("R7 post write addr", ad, 18'hC06 + i);
            chk("R7 post state progress", st_state, (i == 3) ? 3 : 2);
        end
        tick(1, 0, 0, we, ad);
        chk("R7 no write in done", we, 0);
        ts_in = 32'hDEAD_0001;
        tick(1, 1, 0, we, ad);
        chk("R9 done holds", st_state, 3);
        chk("R9 trig_ptr kept", st_trig_ptr, 18'hC05);
        chk("R9 stamp kept", st_trig_stamp, 32'h1234_5678);
        cfg_enable = 1'b0;
        tick(0, 0, 0, we, ad);
        chk("R9 back to idle", st_state, 0);
    endtask

    task automatic t_wrap();
        logic we; logic [17:0] ad;
        int bad = 0;
        cfg_start_hi = 8'd2; cfg_last_hi = 8'd2; cfg_rate = 0; cfg_post_count = 0;
        cfg_enable = 1'b1;
        tick(0, 0, 0, we, ad);
        chk("R4 first_fill on arm", st_first_fill, 1);
        for (int i = 0; i < 1024; i++) begin
            tick(1, 0, 0, we, ad);
            if (!we || ad != 18'h800 + i) bad++;
            if (i == 1022) chk("R4 first_fill before last", st_first_fill, 1);
        end
        chk("R3 full page of writes", bad, 0);
        chk("R4 first_fill cleared", st_first_fill, 0);
        tick(1, 0, 0, we, ad);
        chk("R3 wrap to start", ad, 18'h800);
        tick(0, 0, 1, we, ad);
        chk("R10 sw trigger no write", we, 0);
        chk("R8 zero budget done", st_state, 3);
        chk("R10 R6 sw trig_ptr next addr", st_trig_ptr, 18'h801);
        tick(1, 0, 0, we, ad);
        chk("R8 no write after trigger", we, 0);
        chk("R4 stays clear in done", st_first_fill, 0);
        cfg_enable = 1'b0;
        tick(0, 0, 0, we, ad);
        cfg_enable = 1'b1;
        tick(0, 0, 0, we, ad);
        chk("R4 rearm sets first_fill", st_first_fill, 1);
        tick(1, 0, 1, we, ad);
        chk("R8 trigger write addr", ad, 18'h800);
        chk("R8 done same write", st_state, 3);
        chk("R10 trig_ptr on write", st_trig_ptr, 18'h800);
        cfg_enable = 1'b0;
        tick(0, 0, 0, we, ad);
    endtask

    task automatic t_decim();
        logic we; logic [17:0] ad;
        logic [17:0] nxt;
        cfg_start_hi = 8'd1; cfg_last_hi = 8'd1; cfg_rate = 5'd3; cfg_post_count = 18'd1;
        cfg_enable = 1'b1;
        tick(0, 0, 0, we, ad);
        nxt = 18'h400;
        for (int s = 1; s <= 7; s++) begin
            tick(1, 0, 0, we, ad);
            chk("R5 decimated strobe", we, (s % 3 == 1) ? 1 : 0);
            if (we) begin
                chk("R5 decimated addr", ad, nxt);
                nxt = nxt + 1;
            end
            tick(0, 0, 0, we, ad);
        end
        tick(1, 1, 0, we, ad);
        chk("R6 trigger on kept-out sample", we, 0);
        chk("R6 trig_ptr next addr", st_trig_ptr, 18'h403);
        chk("R7 post with decimation", st_state, 2);
        tick(1, 0, 0, we, ad);
        chk("R5 sample 9 skipped", we, 0);
        tick(1, 0, 0, we, ad);
        chk("R5 R7 sample 10 written", ad, 18'h403);
        chk("R7 done after one", st_state, 3);
        cfg_enable = 1'b0;
        tick(0, 0, 0, we, ad);
        cfg_rate = 5'd1; cfg_enable = 1'b1;
        tick(0, 0, 0, we, ad);
        for (int i = 0; i < 3; i++) begin
            tick(1, 0, 0, we, ad);
            chk("R5 rate one every sample", {we, ad}, {1'b1, 18'h400 + i[17:0]});
        end
        cfg_enable = 1'b0;
        tick(1, 0, 0, we, ad);
        chk("R2 no write when enable drops", we, 0);
        chk("R2 idle after drop", st_state, 0);
        tick(1, 0, 0, we, ad);
        chk("R2 idle stays quiet", we, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk); #1;
        t_reset();
        t_basic();
        t_wrap();
        t_decim();
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule